// File: doc/BRIEF.md
# Watchdog Timer with Selectable Postscaler

This block is a watchdog that runs from a slow free-running oscillator clock, taken here as 31.25 kHz. A fixed divide-by-125 stage makes a base tick every 4 ms. A postscaler counter then stretches that tick by a power of two, picked by a 4-bit configuration field. The timeout therefore ranges from 4 ms (divide by 1) up to about 131 s (divide by 32,768).

Firmware keeps the watchdog quiet by pulsing a clear strobe. Entering sleep, a change of the 3-bit oscillator frequency select field, and a clock-failure flag also restart both counters. A configuration enable bit switches the watchdog on. While that bit is low, a software enable bit can switch it on instead. When the counters expire, the block raises a one-cycle reset request if the device is awake. If the device is asleep (level input `in_sleep_i`), it raises a one-cycle wake-up request instead.

Top module: `wdog_timer`

## Requirements
- R1: While `rst_n` is low, both request outputs are 0 and both counters are held at zero. With select 0, the first request appears 125 clock edges after the edge at which reset is released.
- R2: With select value n (0 to 15), a request appears exactly 125·2^n clock edges after the last edge at which the counters were cleared.
- R3: After a timeout, both counters restart from zero. The next request therefore follows 125·2^n edges after the previous one.
- R4: A one-cycle pulse on `kick_i` clears both counters.
- R5: A one-cycle pulse on `sleep_i` clears both counters.
- R6: Any change of `osc_sel_i` relative to its value in the previous cycle clears both counters.
- R7: A pulse on `clk_fail_i` clears both counters.
- R8: If a clear arrives in the same cycle as an expiry, the clear wins. No request is issued, and the next request comes 125·2^n edges after that clear.
- R9: When `hw_en_i` is 1, the watchdog runs, and `sw_en_i` has no effect on its timing.
- R10: When `hw_en_i` is 0, `sw_en_i` = 1 enables the watchdog. When both are 0, the counters are held at zero and no request is produced.
- R11: A timeout while `in_sleep_i` is 1 gives a one-cycle pulse on `wake_req_o`, and `rst_req_o` stays low.
- R12: A timeout while `in_sleep_i` is 0 gives a one-cycle pulse on `rst_req_o`, and `wake_req_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow oscillator clock (31.25 kHz nominal) |
| rst_n | input | 1 | Synchronous active-low device reset |
| hw_en_i | input | 1 | Configuration enable for the watchdog |
| sw_en_i | input | 1 | Software enable, used only when `hw_en_i` is 0 |
| kick_i | input | 1 | Clear strobe from firmware |
| sleep_i | input | 1 | Sleep-entry strobe, also clears the counters |
| in_sleep_i | input | 1 | High while the device is asleep |
| osc_sel_i | input | 3 | Oscillator frequency select field; a change clears the counters |
| clk_fail_i | input | 1 | Clock-failure flag, clears the counters |
| ps_sel_i | input | 4 | Postscaler select n, division 2^n |
| rst_req_o | output | 1 | One-cycle reset request on timeout while awake |
| wake_req_o | output | 1 | One-cycle wake-up request on timeout while asleep |

## Verification
The checker watches every cycle for four things:
- the two requests are never raised together;
- each request matches the sleep state of the previous cycle;
- a request never lasts more than one cycle;
- no request follows a cycle that carried a clear source or had the watchdog disabled.

The exact timeout length for each select value, the restart after expiry, and the clear-beats-expiry timing cannot be checked that way. Nor can the fact that the software enable is ignored while the configuration enable is set. Those only show up in the bench scenarios, which count edges from a known clear to the resulting pulse.

// File: rtl/wdog_pkg.sv
// Package: wdog_pkg
// Shared types for the watchdog. Assumes nothing beyond plain SystemVerilog.
package wdog_pkg;

    // Individual reasons for restarting the watchdog counters.
    typedef struct packed {
        logic kick;
        logic sleep;
        logic osc_chg;
        logic clk_fail;
        logic off;
    } wdog_clr_t;

    // Reduces the set of clear reasons to a single restart flag.
    function automatic logic any_clear(input wdog_clr_t c);
        return c.kick | c.sleep | c.osc_chg | c.clk_fail | c.off;
    endfunction

endpackage

// File: rtl/wdog_clear_ctl.sv
// Module: wdog_clear_ctl
// Resolves the layered enable and collects every source that restarts the
// watchdog counters. Assumes all inputs are synchronous to clk.
module wdog_clear_ctl
    import wdog_pkg::*;
#(
    parameter int OSC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_en_i,
    input  logic             sw_en_i,
    input  logic             kick_i,
    input  logic             sleep_i,
    input  logic [OSC_W-1:0] osc_sel_i,
    input  logic             clk_fail_i,
    output logic             run_o,
    output logic             clr_o
);

    logic [OSC_W-1:0] osc_q;
    wdog_clr_t        why;

    // Keeps last cycle's oscillator select; reset captures the live value.
    always_ff @(posedge clk) begin
        osc_q <= osc_sel_i;
    end

    // Software enable matters only when the configuration enable is clear.
    always_comb begin
        run_o = hw_en_i ? 1'b1 : sw_en_i;
    end

    // Gathers clear reasons into a struct and reduces them to one flag.
    always_comb begin
        why.kick     = kick_i;
        why.sleep    = sleep_i;
        why.osc_chg  = rst_n && (osc_sel_i != osc_q);
        why.clk_fail = clk_fail_i;
        why.off      = ~run_o;
        clr_o        = any_clear(why);
    end

endmodule

// File: rtl/wdog_base_div.sv
// Module: wdog_base_div
// Fixed divider that turns the oscillator clock into the base watchdog tick.
// Assumes DIV >= 2. The tick is suppressed in any cycle that carries a clear.
module wdog_base_div #(
    parameter int DIV = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic tick_o
);

    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    // Flags the last count of the base period unless a clear overrides it.
    always_comb begin
        tick_o = (cnt == LAST) && !clr_i;
    end

    // Counts oscillator cycles modulo DIV, restarting on reset or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/wdog_postscaler.sv
// Module: wdog_postscaler
// Power-of-two postscaler on the base tick. Select n expires on every 2^n-th
// tick. Assumes 2^SEL_W - 1 <= PS_W so every select value has a counter bit.
module wdog_postscaler #(
    parameter int PS_W  = 16,
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             tick_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             expire_o
);

    logic [PS_W-1:0] ps;
    logic [PS_W-1:0] mask;

    // Builds a mask of the low n bits; expiry is when all of them are set.
    for (genvar g = 0; g < PS_W; g++) begin : g_mask
        assign mask[g] = (g < int'(sel_i));
    end

    // Expires on the tick that would carry out of bit n-1 (every tick for n=0).
    always_comb begin
        expire_o = tick_i && ((ps & mask) == mask);
    end

    // Counts base ticks; restarts on reset, clear or expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i || expire_o) begin
            ps <= '0;
        end else if (tick_i) begin
            ps <= ps + 1'b1;
        end
    end

endmodule

// File: rtl/wdog_timer.sv
// Module: wdog_timer (top)
// Watchdog with a fixed base divider and a selectable power-of-two postscaler.
// On expiry it issues a one-cycle reset request when awake, or a one-cycle
// wake-up request when asleep. Assumes a single slow clock domain.
module wdog_timer #(
    parameter int BASE_DIV = 125,
    parameter int PS_W     = 16,
    parameter int SEL_W    = 4,
    parameter int OSC_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_en_i,
    input  logic             sw_en_i,
    input  logic             kick_i,
    input  logic             sleep_i,
    input  logic             in_sleep_i,
    input  logic [OSC_W-1:0] osc_sel_i,
    input  logic             clk_fail_i,
    input  logic [SEL_W-1:0] ps_sel_i,
    output logic             rst_req_o,
    output logic             wake_req_o
);

    logic run;
    logic clr;
    logic tick;
    logic expire;

    wdog_clear_ctl #(.OSC_W(OSC_W)) u_clr (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_en_i    (hw_en_i),
        .sw_en_i    (sw_en_i),
        .kick_i     (kick_i),
        .sleep_i    (sleep_i),
        .osc_sel_i  (osc_sel_i),
        .clk_fail_i (clk_fail_i),
        .run_o      (run),
        .clr_o      (clr)
    );

    wdog_base_div #(.DIV(BASE_DIV)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr),
        .tick_o (tick)
    );

    wdog_postscaler #(.PS_W(PS_W), .SEL_W(SEL_W)) u_ps (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (clr),
        .tick_i   (tick && run),
        .sel_i    (ps_sel_i),
        .expire_o (expire)
    );

    // Routes an expiry to a reset or a wake-up request, by sleep state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req_o  <= 1'b0;
            wake_req_o <= 1'b0;
        end else begin
            rst_req_o  <= expire && !in_sleep_i;
            wake_req_o <= expire && in_sleep_i;
        end
    end

endmodule

// File: rtl/wdog_timer_chk.sv
// Module: wdog_timer_chk
// Cycle-by-cycle properties of the watchdog outputs, bound to wdog_timer.
module wdog_timer_chk #(
    parameter int OSC_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hw_en_i,
    input logic             sw_en_i,
    input logic             kick_i,
    input logic             sleep_i,
    input logic             in_sleep_i,
    input logic [OSC_W-1:0] osc_sel_i,
    input logic             clk_fail_i,
    input logic             rst_req_o,
    input logic             wake_req_o
);

    // R11 R12: the two requests never coincide
    p_one_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_req_o && wake_req_o));

    // R11: a wake-up request only follows a cycle spent asleep
    p_wake_asleep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req_o |-> $past(in_sleep_i));

    // R12: a reset request only follows a cycle spent awake
    p_rst_awake_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> !$past(in_sleep_i));

    // R12: reset request lasts a single cycle
    p_rst_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o);

    // R11: wake-up request lasts a single cycle
    p_wake_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req_o |=> !wake_req_o);

    // R8: a clear strobe blocks any request in the following cycle
    p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (kick_i || sleep_i || clk_fail_i) |=> !(rst_req_o || wake_req_o));

    // R6: an oscillator select change blocks the following request
    p_osc_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_sel_i != $past(osc_sel_i)) |=> !(rst_req_o || wake_req_o));

    // R10: with both enables low no request follows
    p_off_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_en_i && !sw_en_i) |=> !(rst_req_o || wake_req_o));

endmodule

bind wdog_timer wdog_timer_chk #(.OSC_W(OSC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hw_en_i    (hw_en_i),
    .sw_en_i    (sw_en_i),
    .kick_i     (kick_i),
    .sleep_i    (sleep_i),
    .in_sleep_i (in_sleep_i),
    .osc_sel_i  (osc_sel_i),
    .clk_fail_i (clk_fail_i),
    .rst_req_o  (rst_req_o),
    .wake_req_o (wake_req_o)
);

// File: tb/sim_wdog_timer.sv
// Directed bench for wdog_timer. Inputs change and outputs are sampled on the
// falling edge. A measurement counts rising edges after the edge that
// performed the last clear.
module sim_wdog_timer;

    localparam int CLK_PERIOD = 10;
    localparam int BASE = 125;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_en_i = 1'b1;
    logic       sw_en_i = 1'b0;
    logic       kick_i = 1'b0;
    logic       sleep_i = 1'b0;
    logic       in_sleep_i = 1'b0;
    logic [2:0] osc_sel_i = 3'd2;
    logic       clk_fail_i = 1'b0;
    logic [3:0] ps_sel_i = 4'd0;
    logic       rst_req_o;
    logic       wake_req_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_timer u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_en_i    (hw_en_i),
        .sw_en_i    (sw_en_i),
        .kick_i     (kick_i),
        .sleep_i    (sleep_i),
        .in_sleep_i (in_sleep_i),
        .osc_sel_i  (osc_sel_i),
        .clk_fail_i (clk_fail_i),
        .ps_sel_i   (ps_sel_i),
        .rst_req_o  (rst_req_o),
        .wake_req_o (wake_req_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Waits n falling edges and checks that no request appears meanwhile.
    task automatic idle(input int n, input string req);
        int hits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (rst_req_o || wake_req_o) hits++;
        end
        check(hits == 0, req, hits, 0);
    endtask

    // Counts edges to the next request and checks distance and kind.
    task automatic measure(input int exp, input bit want_wake, input string req);
        int k = 0;
        int kind = 0;
        for (int i = 1; i <= exp + 10; i++) begin
            @(negedge clk);
            if (rst_req_o || wake_req_o) begin
                k = i;
                kind = {30'd0, rst_req_o, wake_req_o};
                break;
            end
        end
        check(k == exp, req, k, exp);
        check(kind == (want_wake ? 1 : 2), req, kind, want_wake ? 1 : 2);
    endtask

    task automatic kick();
        @(negedge clk) kick_i = 1'b1;
        @(negedge clk) kick_i = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(!rst_req_o && !wake_req_o, "R1 outputs in reset", {rst_req_o, wake_req_o}, 0);
        rst_n = 1'b1;
        measure(BASE, 1'b0, "R1 first timeout");
    endtask

    task automatic t_period();
        ps_sel_i = 4'd2;
        kick();
        measure(BASE * 4, 1'b0, "R2 R12 select 2");
        ps_sel_i = 4'd3;
        kick();
        measure(BASE * 8, 1'b0, "R2 R12 select 3");
    endtask

    task automatic t_repeat();
        ps_sel_i = 4'd1;
        kick();
        measure(BASE * 2, 1'b0, "R3 first");
        measure(BASE * 2, 1'b0, "R3 second");
        ps_sel_i = 4'd0;
    endtask

    task automatic t_kick_mid();
        kick();
        idle(100, "R4 before kick");
        kick();
        measure(BASE, 1'b0, "R4 after kick");
    endtask

    task automatic t_sleep();
        kick();
        idle(80, "R5 before sleep");
        @(negedge clk) begin sleep_i = 1'b1; in_sleep_i = 1'b1; end
        @(negedge clk) sleep_i = 1'b0;
        measure(BASE, 1'b1, "R5 R11 wake in sleep");
        in_sleep_i = 1'b0;
    endtask

    task automatic t_osc();
        kick();
        idle(80, "R6 before change");
        @(negedge clk) osc_sel_i = 3'd5;
        @(negedge clk);
        measure(BASE, 1'b0, "R6 after select change");
    endtask

    task automatic t_fail();
        kick();
        idle(90, "R7 before failure");
        @(negedge clk) clk_fail_i = 1'b1;
        @(negedge clk) clk_fail_i = 1'b0;
        measure(BASE, 1'b0, "R7 after clock failure");
    endtask

    task automatic t_same_cycle();
        kick();
        idle(BASE - 1, "R8 lead-in");
        kick_i = 1'b1;
        @(negedge clk) kick_i = 1'b0;
        check(!rst_req_o && !wake_req_o, "R8 clear beats expiry", {rst_req_o, wake_req_o}, 0);
        measure(BASE, 1'b0, "R8 next timeout");
    endtask

    task automatic t_hw_sw();
        hw_en_i = 1'b1;
        kick();
        idle(60, "R9 lead-in");
        sw_en_i = 1'b1;
        idle(10, "R9 sw high");
        sw_en_i = 1'b0;
        measure(BASE - 70, 1'b0, "R9 sw ignored");
    endtask

    task automatic t_sw_only();
        hw_en_i = 1'b0;
        sw_en_i = 1'b0;
        idle(400, "R10 both off");
        sw_en_i = 1'b1;
        measure(BASE, 1'b0, "R10 sw enable");
        sw_en_i = 1'b0;
        hw_en_i = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_period();
        t_repeat();
        t_kick_mid();
        t_sleep();
        t_osc();
        t_fail();
        t_same_cycle();
        t_hw_sw();
        t_sw_only();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule